// File: doc/BRIEF.md
# DDR Prefetch Data-Path Gearbox

This block sits between a memory controller's core logic and its data pins. Internally, data moves as one word of two bus widths per controller cycle. On the pins, data moves as two single-width beats per cycle, one on each half. The design runs on one clock at twice the controller rate, so one fast cycle stands for one half of a controller cycle and one beat.

On the write side, the block pulls words from a write queue and sends each one out as two beats, low half first. It drives a strobe that changes half a fast cycle after each data change, which places it in the middle of each beat. A one-beat low preamble comes before the data. Once the burst ends, both output enables drop and a done pulse is raised.

On the read side, the block receives beats that are edge-aligned with an incoming strobe. It captures one beat on each strobe transition, rising or falling, and pairs the beats back into words. A word-valid flag is raised for each completed pair, and a done pulse comes with the last word. On both sides, the burst length is chosen at start as 2, 4 or 8 beats.

Top module: `ddrgb_gearbox`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `dq_out` is zero and `dq_oe`, `dqs_oe`, `dqs_out`, `wr_pop`, `wr_done`, `rd_valid` and `rd_done` are low.
- R2: `bl_sel` is sampled with a start pulse. Code 2'b00 gives 2 beats, 2'b01 gives 4 beats, and 2'b10 and 2'b11 both give 8 beats. A write burst drives exactly that many beats with `dq_oe` high.
- R3: Each write word is sent as two beats in consecutive fast cycles: bits [DQ_W-1:0] first, then bits [2*DQ_W-1:DQ_W]. Words go out in the order they were popped.
- R4: In the fast cycle after the one in which `wr_start` is sampled, `dqs_oe` is high while `dq_oe` and `dqs_out` are low. This is the preamble. The first beat appears in the cycle after the preamble.
- R5: `dqs_out` changes only at the falling clock edge. During a write burst it goes high half a cycle after the first beat appears, then toggles half a cycle after every following beat.
- R6: In the cycle after the last beat, `dq_oe` and `dqs_oe` are low and `wr_done` is high for exactly one cycle. `dqs_out` is low whenever `dqs_oe` is low.
- R7: A `wr_start` pulse that arrives while a write burst is in progress is ignored. The current burst keeps its length, and no second burst follows.
- R8: While a read is armed, one beat of `dq_in` is captured on each transition of `dqs_in`, rising or falling. Changes on `dq_in` without a strobe transition are not captured.
- R9: The first beat captured in a pair becomes bits [DQ_W-1:0] of `rd_word` and the second becomes the upper half. `rd_valid` pulses for one cycle, and only after both beats of the pair have been captured.
- R10: After BL/2 words, `rd_done` is high together with the last `rd_valid`, and the read side disarms. Strobe transitions after that produce no `rd_valid`.
- R11: `wr_pop` is high for one fast cycle just before each word's first beat is driven. There are exactly BL/2 pops per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the controller rate |
| rst | input | 1 | Synchronous active-high reset |
| bl_sel | input | 2 | Burst length code, sampled with either start pulse |
| wr_start | input | 1 | Starts a write burst when the write side is idle |
| wr_word | input | 2*DQ_W | Head word of the write queue |
| wr_pop | output | 1 | Consumes `wr_word` at the next rising edge |
| dq_out | output | DQ_W | Outgoing beat |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dqs_out | output | 1 | Outgoing strobe, updated on the falling edge |
| dqs_oe | output | 1 | Drive enable for the outgoing strobe |
| wr_done | output | 1 | One-cycle pulse after the last write beat |
| rd_start | input | 1 | Arms the read side for one burst |
| dq_in | input | DQ_W | Incoming beat |
| dqs_in | input | 1 | Incoming strobe, edge-aligned with `dq_in` |
| rd_word | output | 2*DQ_W | Reassembled word |
| rd_valid | output | 1 | `rd_word` holds a complete pair |
| rd_done | output | 1 | Pulses with the final word of a read burst |

## Verification
The bench runs every burst-length code, including the reserved code, and checks every beat against a scoreboard. A design with swapped halves or a wrong beat count would show data mismatches or a wrong beat total at `wr_done`. The strobe is sampled both just after the rising edge and just after the falling edge. This catches a strobe launched on the same edge as the data (edge-aligned where it should be centered), a missing preamble, or a strobe left high when the drive is released. On reads, the bench inserts stall cycles in which data changes but the strobe does not, and sends extra strobe transitions after the burst. A design that samples every cycle, flags valid after only one half, or fails to disarm would then produce extra or corrupted words.

// File: rtl/ddrgb_pkg.sv
`timescale 1ns/1ps
package ddrgb_pkg;

    typedef enum logic [1:0] {
        BURST_2  = 2'b00,
        BURST_4  = 2'b01,
        BURST_8  = 2'b10,
        BURST_8X = 2'b11
    } burst_e;

    localparam int MAX_BEATS = 8;
    localparam int BEAT_CW   = $clog2(MAX_BEATS);
    localparam int WORD_CW   = BEAT_CW - 1;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_PRE,
        WS_DATA
    } wr_state_e;

    typedef struct packed {
        logic dq_oe;
        logic dqs_oe;
        logic dqs_lvl;
        logic done;
    } wr_ctl_t;

    function automatic logic [BEAT_CW-1:0] last_beat(burst_e b);
        case (b)
            BURST_2: return BEAT_CW'(1);
            BURST_4: return BEAT_CW'(3);
            default: return BEAT_CW'(MAX_BEATS - 1);
        endcase
    endfunction

    function automatic logic [WORD_CW-1:0] last_word(burst_e b);
        case (b)
            BURST_2: return WORD_CW'(0);
            BURST_4: return WORD_CW'(1);
            default: return WORD_CW'(MAX_BEATS / 2 - 1);
        endcase
    endfunction

endpackage

// File: rtl/ddrgb_wr_serializer.sv
`timescale 1ns/1ps
module ddrgb_wr_serializer
    import ddrgb_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bl_sel,
    input  logic              start,
    input  logic [2*DQ_W-1:0] word,
    output logic              pop,
    output logic [DQ_W-1:0]   dq,
    output wr_ctl_t           ctl
);
    localparam int WORD_W = 2 * DQ_W;

    wr_state_e          state;
    logic [BEAT_CW-1:0] beat;
    logic [BEAT_CW-1:0] last;
    logic [DQ_W-1:0]    hi_hold;
    logic [DQ_W-1:0]    dq_r;
    wr_ctl_t            ctl_r;
    logic               last_hit;

    assign last_hit = (beat == last);
    // A new word is consumed at the edge that launches its low half.
    assign pop = (state == WS_PRE) || (state == WS_DATA && beat[0] && !last_hit);
    assign dq  = dq_r;
    assign ctl = ctl_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WS_IDLE;
            beat    <= '0;
            last    <= '0;
            hi_hold <= '0;
            dq_r    <= '0;
            ctl_r   <= '0;
        end else begin
            ctl_r.done <= 1'b0;
            unique case (state)
                WS_IDLE: begin
                    if (start) begin
                        state         <= WS_PRE;
                        last          <= last_beat(burst_e'(bl_sel));
                        ctl_r.dqs_oe  <= 1'b1;
                        ctl_r.dqs_lvl <= 1'b0;
                    end
                end
                WS_PRE: begin
                    dq_r          <= word[DQ_W-1:0];
                    hi_hold       <= word[WORD_W-1:DQ_W];
                    ctl_r.dq_oe   <= 1'b1;
                    ctl_r.dqs_lvl <= 1'b1;
                    beat          <= '0;
                    state         <= WS_DATA;
                end
                WS_DATA: begin
                    if (last_hit) begin
                        state         <= WS_IDLE;
                        dq_r          <= '0;
                        ctl_r.dq_oe   <= 1'b0;
                        ctl_r.dqs_oe  <= 1'b0;
                        ctl_r.dqs_lvl <= 1'b0;
                        ctl_r.done    <= 1'b1;
                    end else begin
                        beat          <= beat + 1'b1;
                        ctl_r.dqs_lvl <= ~ctl_r.dqs_lvl;
                        if (!beat[0]) begin
                            dq_r <= hi_hold;
                        end else begin
                            dq_r    <= word[DQ_W-1:0];
                            hi_hold <= word[WORD_W-1:DQ_W];
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    p_pop_in_burst_r11: assert property (@(posedge clk) disable iff (rst)
        pop |-> ctl_r.dqs_oe);

    p_preamble_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_r.dqs_oe) |-> (!ctl_r.dq_oe && !ctl_r.dqs_lvl));

    p_done_release_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_r.done |-> (!ctl_r.dq_oe && $past(ctl_r.dq_oe)));

endmodule

// File: rtl/ddrgb_strobe_launch.sv
`timescale 1ns/1ps
module ddrgb_strobe_launch (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic dqs
);
    // Falling-edge launch puts the strobe half a fast cycle behind the data.
    always_ff @(negedge clk) begin
        if (rst) dqs <= 1'b0;
        else     dqs <= lvl;
    end
endmodule

// File: rtl/ddrgb_rd_deserializer.sv
`timescale 1ns/1ps
module ddrgb_rd_deserializer
    import ddrgb_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bl_sel,
    input  logic              start,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic              dqs_in,
    output logic [2*DQ_W-1:0] word,
    output logic              valid,
    output logic              done
);
    logic               armed;
    logic               half;
    logic               dqs_q;
    logic               strobe_edge;
    logic [DQ_W-1:0]    lo_hold;
    logic [WORD_CW-1:0] cnt;
    logic [WORD_CW-1:0] last;

    assign strobe_edge = dqs_in ^ dqs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            half    <= 1'b0;
            dqs_q   <= 1'b0;
            lo_hold <= '0;
            cnt     <= '0;
            last    <= '0;
            word    <= '0;
            valid   <= 1'b0;
            done    <= 1'b0;
        end else begin
            dqs_q <= dqs_in;
            valid <= 1'b0;
            done  <= 1'b0;
            if (!armed) begin
                if (start) begin
                    armed <= 1'b1;
                    half  <= 1'b0;
                    cnt   <= '0;
                    last  <= last_word(burst_e'(bl_sel));
                end
            end else if (strobe_edge) begin
                if (!half) begin
                    lo_hold <= dq_in;
                    half    <= 1'b1;
                end else begin
                    word  <= {dq_in, lo_hold};
                    valid <= 1'b1;
                    half  <= 1'b0;
                    if (cnt == last) begin
                        done  <= 1'b1;
                        armed <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    p_valid_when_armed_r9: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(armed));

    p_pair_complete_r9: assert property (@(posedge clk) disable iff (rst)
        valid |-> !half);

    p_done_disarms_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (valid && !armed));

endmodule

// File: rtl/ddrgb_gearbox.sv
`timescale 1ns/1ps
module ddrgb_gearbox
    import ddrgb_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bl_sel,
    input  logic              wr_start,
    input  logic [2*DQ_W-1:0] wr_word,
    output logic              wr_pop,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              dqs_out,
    output logic              dqs_oe,
    output logic              wr_done,
    input  logic              rd_start,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic              dqs_in,
    output logic [2*DQ_W-1:0] rd_word,
    output logic              rd_valid,
    output logic              rd_done
);
    wr_ctl_t wctl;

    ddrgb_wr_serializer #(.DQ_W(DQ_W)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .bl_sel (bl_sel),
        .start  (wr_start),
        .word   (wr_word),
        .pop    (wr_pop),
        .dq     (dq_out),
        .ctl    (wctl)
    );

    ddrgb_strobe_launch u_dqs (
        .clk (clk),
        .rst (rst),
        .lvl (wctl.dqs_lvl),
        .dqs (dqs_out)
    );

    assign dq_oe   = wctl.dq_oe;
    assign dqs_oe  = wctl.dqs_oe;
    assign wr_done = wctl.done;

    ddrgb_rd_deserializer #(.DQ_W(DQ_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .bl_sel (bl_sel),
        .start  (rd_start),
        .dq_in  (dq_in),
        .dqs_in (dqs_in),
        .word   (rd_word),
        .valid  (rd_valid),
        .done   (rd_done)
    );

    p_center_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> (dqs_out != $past(dqs_out)));

    p_idle_strobe_low_r6: assert property (@(posedge clk) disable iff (rst)
        !dqs_oe |-> !dqs_out);

    p_data_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dqs_oe);

endmodule

// File: tb/tb_ddrgb_gearbox.sv
`timescale 1ns/1ps
module tb_ddrgb_gearbox;
    localparam int DQ_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        bl_sel = 2'b00;
    logic              wr_start = 1'b0;
    logic [2*DQ_W-1:0] wr_word = '0;
    logic              wr_pop;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_oe, dqs_out, dqs_oe, wr_done;
    logic              rd_start = 1'b0;
    logic [DQ_W-1:0]   dq_in = '0;
    logic              dqs_in = 1'b0;
    logic [2*DQ_W-1:0] rd_word;
    logic              rd_valid, rd_done;

    always #4 clk = ~clk;

    ddrgb_gearbox #(.DQ_W(DQ_W)) dut (
        .clk(clk), .rst(rst), .bl_sel(bl_sel), .wr_start(wr_start),
        .wr_word(wr_word), .wr_pop(wr_pop), .dq_out(dq_out), .dq_oe(dq_oe),
        .dqs_out(dqs_out), .dqs_oe(dqs_oe), .wr_done(wr_done),
        .rd_start(rd_start), .dq_in(dq_in), .dqs_in(dqs_in),
        .rd_word(rd_word), .rd_valid(rd_valid), .rd_done(rd_done)
    );

    int checks = 0;
    int errors = 0;
    logic [2*DQ_W-1:0] wsrc[$];
    logic [DQ_W-1:0]   wexp[$];
    logic [2*DQ_W-1:0] rexp[$];
    int  wr_beats_exp = 0, wb_idx = 0, pop_cnt = 0;
    int  rd_words_exp = 0, rv_cnt = 0;
    bit  wr_done_seen = 0, rd_done_seen = 0;
    int  seed = 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2*DQ_W-1:0] mk_word();
        seed = seed + 1;
        return {DQ_W'(seed * 37 + 5), DQ_W'(seed * 91 + 3)};
    endfunction

    // Write-queue model: pops sampled mid-cycle, head advanced after the edge.
    initial begin
        forever begin
            bit p;
            @(negedge clk);
            p = wr_pop;
            @(posedge clk);
            #1;
            if (p && wsrc.size() > 0) void'(wsrc.pop_front());
            wr_word = (wsrc.size() > 0) ? wsrc[0] : '0;
        end
    end

    // Monitor / scoreboard
    initial begin
        forever begin
            bit beat_now;
            int idx;
            @(posedge clk);
            #2;
            if (rst) continue;
            beat_now = dq_oe;
            idx = wb_idx;
            if (wr_pop) pop_cnt++;
            if (dq_oe) begin
                if (wexp.size() == 0) begin
                    chk(0, "R2 unexpected beat", dq_out, 0);
                end else begin
                    logic [DQ_W-1:0] e;
                    e = wexp.pop_front();
                    chk(dq_out == e, "R3 beat data", dq_out, e);
                end
                // R5: strobe still holds previous level just after the data edge
                chk(dqs_out == 1'((idx % 2) != 0), "R5 strobe before fall", dqs_out, 1'((idx % 2) != 0));
                wb_idx++;
            end
            if (wr_done) begin
                chk(wb_idx == wr_beats_exp, "R2 beat count", wb_idx, wr_beats_exp);
                chk(pop_cnt == wr_beats_exp / 2, "R11 pop count", pop_cnt, wr_beats_exp / 2);
                chk(!dqs_oe && !dq_oe, "R6 drive released", {dqs_oe, dq_oe}, 0);
                wb_idx = 0;
                pop_cnt = 0;
                wr_done_seen = 1;
            end
            if (rd_valid) begin
                if (rexp.size() == 0) begin
                    chk(0, "R10 unexpected word", rd_word, 0);
                end else begin
                    logic [2*DQ_W-1:0] e;
                    e = rexp.pop_front();
                    chk(rd_word == e, "R9 word", rd_word, e);
                end
                rv_cnt++;
            end
            if (rd_done) begin
                chk(rd_valid && rv_cnt == rd_words_exp, "R10 word count", rv_cnt, rd_words_exp);
                rv_cnt = 0;
                rd_done_seen = 1;
            end
            #4;
            if (beat_now)
                chk(dqs_out == 1'((idx % 2) == 0), "R5 strobe after fall", dqs_out, 1'((idx % 2) == 0));
        end
    end

    task automatic write_burst(input logic [1:0] code, input int beats, input bit poke);
        for (int k = 0; k < beats / 2; k++) begin
            logic [2*DQ_W-1:0] w;
            w = mk_word();
            wsrc.push_back(w);
            wexp.push_back(w[DQ_W-1:0]);
            wexp.push_back(w[2*DQ_W-1:DQ_W]);
        end
        wr_beats_exp = beats;
        wr_done_seen = 0;
        @(negedge clk);
        bl_sel = code;
        wr_start = 1'b1;
        @(posedge clk);
        #1 wr_start = 1'b0;
        #5;
        chk(dqs_oe && !dq_oe && !dqs_out, "R4 preamble", {dqs_oe, dq_oe, dqs_out}, 3'b100);
        if (poke) begin
            @(negedge clk);
            bl_sel = 2'b10;
            wr_start = 1'b1;
            @(posedge clk);
            #1 wr_start = 1'b0;
        end
        while (!wr_done_seen) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
        chk(!dqs_oe && !dq_oe && !dqs_out, "R7 no follow-on burst", {dqs_oe, dq_oe, dqs_out}, 0);
    endtask

    task automatic read_burst(input logic [1:0] code, input int words, input bit stall);
        logic [2*DQ_W-1:0] ws[$];
        for (int k = 0; k < words; k++) begin
            logic [2*DQ_W-1:0] w;
            w = mk_word();
            ws.push_back(w);
            rexp.push_back(w);
        end
        rd_words_exp = words;
        rd_done_seen = 0;
        @(negedge clk);
        bl_sel = code;
        rd_start = 1'b1;
        @(posedge clk);
        #1 rd_start = 1'b0;
        @(negedge clk);
        dq_in = 8'h5A;
        for (int k = 0; k < words; k++) begin
            @(negedge clk);
            dq_in = ws[k][DQ_W-1:0];
            dqs_in = ~dqs_in;
            if (stall) begin
                @(negedge clk);
                dq_in = 8'hEE;   // R8: data change without strobe edge
            end
            @(negedge clk);
            dq_in = ws[k][2*DQ_W-1:DQ_W];
            dqs_in = ~dqs_in;
        end
        while (!rd_done_seen) @(posedge clk);
        // R10: trailing strobe edges after the burst must be ignored
        @(negedge clk);
        dq_in = 8'h11;
        dqs_in = ~dqs_in;
        @(negedge clk);
        dq_in = 8'h22;
        dqs_in = ~dqs_in;
        repeat (3) @(posedge clk);
        #2;
        chk(rexp.size() == 0 && rv_cnt == 0, "R10 disarmed", rv_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        chk(dq_out == 0 && !dq_oe && !dqs_oe && !dqs_out && !wr_pop && !wr_done
            && !rd_valid && !rd_done, "R1 in reset", {dq_oe, dqs_oe, dqs_out, wr_pop}, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        #2;
        chk(dq_out == 0 && !dq_oe && !dqs_oe && !dqs_out && !wr_pop && !wr_done
            && !rd_valid && !rd_done, "R1 after reset", {dq_oe, dqs_oe, dqs_out, wr_pop}, 0);

        write_burst(2'b00, 2, 0);
        write_burst(2'b01, 4, 0);
        write_burst(2'b10, 8, 0);
        write_burst(2'b11, 8, 0);
        write_burst(2'b00, 2, 1);   // R7: start while busy
        write_burst(2'b01, 4, 1);

        read_burst(2'b00, 1, 0);
        read_burst(2'b01, 2, 1);
        read_burst(2'b10, 4, 0);
        read_burst(2'b11, 4, 1);

        chk(wexp.size() == 0, "R2 write scoreboard drained", wexp.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule